// File: doc/BRIEF.md
# Register-Window Peripheral Bus Access Engine

This block lets a control processor perform single reads and writes on a separate peripheral bus through a window of four 64-bit registers: base, command, data and status. Software describes a transfer in the command register as a direction, a byte count and a 32-bit address. A read starts as soon as a command carrying the read flag is written, and its result lands in the data register. A write starts when software writes the data register while the command register holds a write command.

Every transfer lies inside one 8-byte aligned sector. Data is not right-justified. Each byte sits on the lane of the 64-bit word that matches its address within the sector, with big-endian lane order: byte offset 0 is the most significant byte. The engine builds byte enables from the size and the low address bits. It rejects illegal sizes and transfers that would cross a sector, and it reports done, error and overrun in the status register.

The master side is a valid/ready request. Once `m_valid` rises, the engine holds it and every request field stable until it samples `m_ready` high on a clock edge. The bus may stall for any number of cycles. The edge with both high completes the transfer and carries the read data on `m_rdata`. The engine accepts no new launch while a request is outstanding.

Top module: `bus_window_engine`

## Requirements
- R1: After reset the status register reads 64'h8000_0000_0000_0000 (done set, error and overrun clear), command and data read zero, and `m_valid` is low.
- R2: A write to the command register (offset 0x41) whose bit 63 is 1 starts a bus read on the next cycle: `m_valid`=1, `m_we`=0, `m_addr` equals command bits [31:0], and `m_nbytes` equals the command size field.
- R3: The command register holds the read flag in bit 63, the byte count in bits [58:52] and the address in bits [31:0]. A command write with bit 63 clear stores the command and starts no transfer.
- R4: A write to the data register (offset 0x42) while the command register holds a write command stores the value and starts a bus write on the next cycle, with `m_we`=1, the stored command's address and size, and `m_wdata` equal to the written value.
- R5: Byte offset k = address[2:0] + i lies in data bits [63-8k -: 8] and is enabled by `m_be[7-k]`. Exactly the lanes for offsets from address[2:0] up to address[2:0]+size-1 are enabled.
- R6: When a read completes, the data register takes `m_rdata` on the enabled lanes and zero on every other lane.
- R7: Legal sizes are 1, 2, 4 and 8, and address[2:0]+size must not exceed 8. A launch attempt that breaks either rule raises no request and sets status bit 62 (error). The next legal launch clears that bit.
- R8: Status bit 63 (done) clears on the edge that launches a transfer and sets again on the edge where `m_valid` and `m_ready` are both high.
- R9: While a transfer is outstanding, writes to the command or data registers change neither register and launch nothing. They set status bit 61 (overrun), which stays set until reset.
- R10: Writes to the status (0x43) and base (0x40) registers have no effect, and the base register reads zero.
- R11: A register read returns its value on `reg_rdata` one cycle after `reg_rd`. Command and data return their held values, and any other offset returns zero.
- R12: While `m_valid` is high and `m_ready` is low, `m_valid` and all request fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_off | input | 8 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after `reg_rd` |
| m_valid | output | 1 | Bus request valid |
| m_ready | input | 1 | Bus acknowledge |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Byte address |
| m_nbytes | output | 4 | Transfer byte count |
| m_be | output | 8 | Byte-lane enables, bit j covers data bits [8j+7:8j] |
| m_wdata | output | 64 | Write data on memory lanes |
| m_rdata | input | 64 | Read data, sampled when `m_valid` and `m_ready` are both high |

## Verification
A launch shows on the master port one cycle after the register write strobe. The done bit falls on that same edge. Register read data appears one cycle after `reg_rd`, so the bench drives strobes on falling edges and samples at the next falling edge. The done bit and read data update on the edge that carries the handshake. To cover back-pressure, the bench holds `m_ready` low for one full cycle on every request and confirms the request is unchanged. It then raises `m_ready` for one cycle and checks at the next falling edge that `m_valid` has dropped.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 7;
  localparam int OFF_W  = 8;
  localparam int LANES  = WORD_W / 8;
  localparam int LOFF_W = $clog2(LANES);
  localparam int NB_W   = LOFF_W + 1;

  localparam logic [OFF_W-1:0] OFF_BASE = 8'h40;
  localparam logic [OFF_W-1:0] OFF_CMD  = 8'h41;
  localparam logic [OFF_W-1:0] OFF_DATA = 8'h42;
  localparam logic [OFF_W-1:0] OFF_STAT = 8'h43;

  // positions in LSB-first numbering
  localparam int CMD_RD_BIT  = 63;
  localparam int CMD_SZ_LO   = 52;
  localparam int STAT_DONE   = 63;
  localparam int STAT_ERR    = 62;
  localparam int STAT_OVR    = 61;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [NB_W-1:0]   nbytes;
    logic [LANES-1:0]  be;
  } bus_req_t;
endpackage

// File: rtl/bwe_size_check.sv
module bwe_size_check #(
  parameter int SIZE_W = 7,
  parameter int LANES  = 8,
  localparam int LOFF_W = $clog2(LANES),
  localparam int NB_W   = LOFF_W + 1,
  localparam int SUM_W  = SIZE_W + 1
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [LOFF_W-1:0] loff,
  output logic              legal,
  output logic [LANES-1:0]  be,
  output logic [NB_W-1:0]   nbytes
);
  logic [SUM_W-1:0] size_x, loff_x, end_x;
  logic pow2, fits;

  always_comb begin
    size_x = {1'b0, size};
    loff_x = SUM_W'(loff);
    end_x  = loff_x + size_x;
    pow2   = (size != '0) && ((size & (size - 1'b1)) == '0) && (size <= SIZE_W'(LANES));
    fits   = end_x <= SUM_W'(LANES);
    legal  = pow2 && fits;
    nbytes = size[NB_W-1:0];
  end

  // lane j carries sector byte offset LANES-1-j
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int K = LANES - 1 - j;
    assign be[j] = legal && (SUM_W'(K) >= loff_x) && (SUM_W'(K) < end_x);
  end
endmodule

// File: rtl/bwe_lane_mask.sv
module bwe_lane_mask #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] mask
);
  for (genvar j = 0; j < LANES; j++) begin : g_m
    assign mask[8*j +: 8] = {8{be[j]}};
  end
endmodule

// File: rtl/bwe_bus_port.sv
module bwe_bus_port
  import bwe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  bus_req_t          req_in,
  input  logic [WORD_W-1:0] wdata_in,
  input  logic              m_ready,
  output logic              m_valid,
  output bus_req_t          req_q,
  output logic [WORD_W-1:0] m_wdata,
  output logic              ack,
  output logic              busy
);
  assign ack  = m_valid && m_ready;
  assign busy = m_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      req_q   <= '0;
      m_wdata <= '0;
    end else if (launch && !m_valid) begin
      m_valid <= 1'b1;
      req_q   <= req_in;
      m_wdata <= wdata_in;
    end else if (ack) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_window_engine.sv
module bus_window_engine
  import bwe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [NB_W-1:0]   m_nbytes,
  output logic [LANES-1:0]  m_be,
  output logic [WORD_W-1:0] m_wdata,
  input  logic [WORD_W-1:0] m_rdata
);
  logic [WORD_W-1:0] cmd_q, data_q;
  logic done_q, err_q, ovr_q;
  logic wr_cmd, wr_dat, busy, ack;
  logic [WORD_W-1:0] src_cmd;
  logic try_rd, try_wr, attempt, legal, launch;
  logic [LANES-1:0] be_new;
  logic [NB_W-1:0] nb_new;
  logic [WORD_W-1:0] rmask;
  bus_req_t req_new, req_q;

  assign wr_cmd = reg_wr && (reg_off == OFF_CMD);
  assign wr_dat = reg_wr && (reg_off == OFF_DATA);

  // a read launch decodes the incoming command, a write launch the held one
  assign src_cmd = wr_cmd ? reg_wdata : cmd_q;
  assign try_rd  = wr_cmd && !busy && reg_wdata[CMD_RD_BIT];
  assign try_wr  = wr_dat && !busy && !cmd_q[CMD_RD_BIT];
  assign attempt = try_rd || try_wr;
  assign launch  = attempt && legal;

  bwe_size_check #(.SIZE_W(SIZE_W), .LANES(LANES)) u_size (
    .size   (src_cmd[CMD_SZ_LO +: SIZE_W]),
    .loff   (src_cmd[LOFF_W-1:0]),
    .legal  (legal),
    .be     (be_new),
    .nbytes (nb_new)
  );

  assign req_new = '{we: try_wr, addr: src_cmd[ADDR_W-1:0], nbytes: nb_new, be: be_new};

  bwe_bus_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .req_in   (req_new),
    .wdata_in (reg_wdata),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .req_q    (req_q),
    .m_wdata  (m_wdata),
    .ack      (ack),
    .busy     (busy)
  );

  assign m_we     = req_q.we;
  assign m_addr   = req_q.addr;
  assign m_nbytes = req_q.nbytes;
  assign m_be     = req_q.be;

  bwe_lane_mask #(.LANES(LANES)) u_mask (
    .be   (req_q.be),
    .mask (rmask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      done_q <= 1'b1;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if ((wr_cmd || wr_dat) && busy) ovr_q <= 1'b1;
      if (wr_cmd && !busy) cmd_q <= reg_wdata;
      if (wr_dat && !busy) data_q <= reg_wdata;
      else if (ack && !req_q.we) data_q <= m_rdata & rmask;
      if (attempt) err_q <= !legal;
      if (launch) done_q <= 1'b0;
      else if (ack) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_off)
        OFF_CMD:  reg_rdata <= cmd_q;
        OFF_DATA: reg_rdata <= data_q;
        OFF_STAT: begin
          reg_rdata <= '0;
          reg_rdata[STAT_DONE] <= done_q;
          reg_rdata[STAT_ERR]  <= err_q;
          reg_rdata[STAT_OVR]  <= ovr_q;
        end
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bwe_checker.sv
module bwe_checker
  import bwe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [NB_W-1:0]   m_nbytes,
  input logic [LANES-1:0]  m_be,
  input logic [WORD_W-1:0] m_wdata,
  input logic              done_q,
  input logic              err_q,
  input logic              ovr_q,
  input logic [WORD_W-1:0] data_q,
  input logic [WORD_W-1:0] cmd_q,
  input logic              reg_wr,
  input logic [OFF_W-1:0]  reg_off
);
  function automatic logic [WORD_W-1:0] expand(input logic [LANES-1:0] b);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{b[i]}};
    return r;
  endfunction

  // R12
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_be) && $stable(m_we) && $stable(m_wdata));
  // R8
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !done_q);
  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |=> done_q && !m_valid);
  // R5
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> $countones(m_be) == int'(m_nbytes));
  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_we |=> (data_q & ~expand($past(m_be))) == '0);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  // R9
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && reg_wr && (reg_off == OFF_CMD) |=> $stable(cmd_q) && ovr_q);
  // R7
  err_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !m_valid);
endmodule

bind bus_window_engine bwe_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_nbytes (m_nbytes),
  .m_be     (m_be),
  .m_wdata  (m_wdata),
  .done_q   (done_q),
  .err_q    (err_q),
  .ovr_q    (ovr_q),
  .data_q   (data_q),
  .cmd_q    (cmd_q),
  .reg_wr   (reg_wr),
  .reg_off  (reg_off)
);

// File: tb/bus_window_engine_test.sv
module bus_window_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_off = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        m_valid, m_ready = 1'b0, m_we;
  logic [31:0] m_addr;
  logic [3:0]  m_nbytes;
  logic [7:0]  m_be;
  logic [63:0] m_wdata, m_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  localparam logic [63:0] RDPAT = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ST_OK = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic        rd;
    logic [6:0]  sz;
    logic [31:0] addr;
    logic [63:0] pay;
    logic [7:0]  be;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 7'd1, 32'h0000_03F8, 64'h0, 8'h80},
    '{1'b1, 7'd1, 32'h0000_03FD, 64'h0, 8'h04},
    '{1'b1, 7'd2, 32'h0000_1006, 64'h0, 8'h03},
    '{1'b1, 7'd4, 32'h0000_1004, 64'h0, 8'h0F},
    '{1'b1, 7'd8, 32'h0000_2000, 64'h0, 8'hFF},
    '{1'b0, 7'd1, 32'h0000_0013, 64'h1122_3344_5566_7788, 8'h10},
    '{1'b0, 7'd4, 32'h0000_0020, 64'hDEAD_BEEF_0BAD_F00D, 8'hF0},
    '{1'b0, 7'd2, 32'h0000_0031, 64'hA5A5_5A5A_C3C3_3C3C, 8'h60}
  };

  always #2 clk = ~clk;

  bus_window_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_valid(m_valid), .m_ready(m_ready),
    .m_we(m_we), .m_addr(m_addr), .m_nbytes(m_nbytes), .m_be(m_be),
    .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  function automatic logic [63:0] mk_cmd(input logic rd, input logic [6:0] sz, input logic [31:0] a);
    return {rd, 4'b0, sz, 20'b0, a};
  endfunction

  function automatic logic [63:0] lanes(input logic [7:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (b[i]) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] off, input logic [63:0] d);
    reg_off = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] off, output logic [63:0] d);
    reg_off = off; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // serve one request: one stall cycle, then acknowledge
  task automatic serve(input logic we, input logic [31:0] a, input logic [6:0] sz,
                       input logic [7:0] be, input logic [63:0] wd);
    check(m_valid === 1'b1, "R2/R4 request valid", {63'b0, m_valid}, 64'd1);
    check(m_we === we, "R2/R4 direction", {63'b0, m_we}, {63'b0, we});
    check(m_addr === a, "R3 address", {32'b0, m_addr}, {32'b0, a});
    check(m_nbytes === sz[3:0], "R3 size", {60'b0, m_nbytes}, {60'b0, sz[3:0]});
    check(m_be === be, "R5 byte enables", {56'b0, m_be}, {56'b0, be});
    if (we) check(m_wdata === wd, "R4 write data", m_wdata, wd);
    @(negedge clk);
    check(m_valid === 1'b1 && m_addr === a && m_be === be, "R12 hold under stall",
          {m_valid, 23'b0, m_be, m_addr}, {1'b1, 23'b0, be, a});
    m_ready = 1'b1; m_rdata = RDPAT;
    @(negedge clk);
    m_ready = 1'b0; m_rdata = '0;
    check(m_valid === 1'b0, "R8 request retired", {63'b0, m_valid}, 64'd0);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    summary();
  end

  initial begin
    logic [63:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(m_valid === 1'b0, "R1 idle after reset", {63'b0, m_valid}, 64'd0);
    reg_read(8'h43, rv); check(rv === ST_OK, "R1 status", rv, ST_OK);
    reg_read(8'h41, rv); check(rv === 64'd0, "R1 command", rv, 64'd0);
    reg_read(8'h42, rv); check(rv === 64'd0, "R1 data", rv, 64'd0);
    reg_read(8'h10, rv); check(rv === 64'd0, "R11 unmapped offset", rv, 64'd0);

    // table of transfers
    for (int i = 0; i < 8; i++) begin
      vec_t v = VECS[i];
      if (v.rd) begin
        reg_write(8'h41, mk_cmd(1'b1, v.sz, v.addr));
        serve(1'b0, v.addr, v.sz, v.be, 64'd0);
        reg_read(8'h42, rv);
        check(rv === (RDPAT & lanes(v.be)), "R6 read lanes", rv, RDPAT & lanes(v.be));
      end else begin
        reg_write(8'h41, mk_cmd(1'b0, v.sz, v.addr));
        check(m_valid === 1'b0, "R3 write command alone", {63'b0, m_valid}, 64'd0);
        reg_write(8'h42, v.pay);
        serve(1'b1, v.addr, v.sz, v.be, v.pay);
      end
      reg_read(8'h43, rv); check(rv === ST_OK, "R8 status done", rv, ST_OK);
    end

    // R7 illegal size
    reg_write(8'h41, mk_cmd(1'b1, 7'd3, 32'h100));
    check(m_valid === 1'b0, "R7 bad size no request", {63'b0, m_valid}, 64'd0);
    reg_read(8'h43, rv); check(rv === 64'hC000_0000_0000_0000, "R7 bad size error", rv, 64'hC000_0000_0000_0000);
    // R7 sector crossing
    reg_write(8'h41, mk_cmd(1'b1, 7'd4, 32'h106));
    check(m_valid === 1'b0, "R7 crossing no request", {63'b0, m_valid}, 64'd0);
    reg_read(8'h43, rv); check(rv === 64'hC000_0000_0000_0000, "R7 crossing error", rv, 64'hC000_0000_0000_0000);
    // R7 legal launch clears error
    reg_write(8'h41, mk_cmd(1'b1, 7'd1, 32'h107));
    serve(1'b0, 32'h107, 7'd1, 8'h01, 64'd0);
    reg_read(8'h43, rv); check(rv === ST_OK, "R7 error cleared", rv, ST_OK);

    // R10 status/base writes ignored
    reg_write(8'h43, 64'h0);
    reg_write(8'h40, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_read(8'h43, rv); check(rv === ST_OK, "R10 status write ignored", rv, ST_OK);
    reg_read(8'h40, rv); check(rv === 64'd0, "R10 base reads zero", rv, 64'd0);

    // R11 command readback
    reg_write(8'h41, mk_cmd(1'b0, 7'd1, 32'h20));
    reg_read(8'h41, rv); check(rv === mk_cmd(1'b0, 7'd1, 32'h20), "R11 command readback", rv, mk_cmd(1'b0, 7'd1, 32'h20));

    // R8/R9 busy behaviour
    reg_write(8'h41, mk_cmd(1'b1, 7'd8, 32'h4000));
    reg_read(8'h43, rv); check(rv === 64'd0, "R8 done low while busy", rv, 64'd0);
    reg_write(8'h41, mk_cmd(1'b1, 7'd1, 32'h5000));
    reg_write(8'h42, 64'h7777_7777_7777_7777);
    serve(1'b0, 32'h4000, 7'd8, 8'hFF, 64'd0);
    reg_read(8'h41, rv); check(rv === mk_cmd(1'b1, 7'd8, 32'h4000), "R9 command kept", rv, mk_cmd(1'b1, 7'd8, 32'h4000));
    reg_read(8'h42, rv); check(rv === RDPAT, "R9 data kept", rv, RDPAT);
    reg_read(8'h43, rv); check(rv === 64'hA000_0000_0000_0000, "R9 overrun sticky", rv, 64'hA000_0000_0000_0000);

    summary();
  end
endmodule